// File: doc/BRIEF.md
# Line-PLL Time-Constant and Sync-Gating Controller

This block picks the loop-filter time constant for a horizontal phase-locked loop and opens or narrows the window through which separated sync pulses reach the phase detector. The choice depends on a two-bit mode, the sync-lock flag, the vertical-retrace indication and a noise flag. The block derives that noise flag itself by qualifying a noise comparator over whole fields. It runs on the line-locked clock. Line and vertical-pulse strobes give it its position inside the line and inside the field.

The time-constant code is re-evaluated only on line strobes. A separate boost bit marks the retrace period, when the loop is pulled harder. Sync is gated in two cases. The first is whenever the slow constant is in force. The second is a band of lines after the vertical pulse, when pseudo-sync pulses of anti-copy signals must be excluded. Inside a gated interval only pulses close to the expected sync position pass.

Top module: `hpll_tc_ctrl`

## Requirements
- R1: With mode 00 (fast), the code registered on a line strobe is 00 (fast) with boost 0, whatever lock, noise or retrace.
- R2: With mode 01 (auto), lock high and noise flag clear, the code registered on a line strobe is 01 (medium), and boost equals the retrace input.
- R3: With lock high, and either mode 10 or 11 (slow) or mode 01 with the noise flag set, the code registered on a line strobe is 10 (slow), and boost equals the retrace input.
- R4: With lock low and any mode other than 00, the code registered on a line strobe is 01 (medium) with boost 0.
- R5: The code and boost change only in the cycle after a line strobe and hold otherwise.
- R6: The noise comparator counts only while the line count since the last vertical strobe is within 65 to 79. The line count is 0 after the strobe and rises by one per line strobe. Comparator pulses on other lines have no effect on the flag.
- R7: At each vertical strobe the flag is set if the comparator fired in the window of the field just ended and also in the field before it. It is visible one cycle after the strobe.
- R8: At a vertical strobe that ends a field with no comparator pulse in its window, the flag clears.
- R9: While the code is 10, the gate is high only when the clock count since the last line strobe is within 11 to 53 (±21 clocks about position 32). The count is 0 in the cycle after the strobe.
- R10: In modes 00 or 01, with the anti-copy enable high and the noise flag clear, the same window applies on lines 11 to 22 after the vertical strobe.
- R11: Outside those cases the gate is high, and the gated sync output is the sync input ANDed with the gate.
- R12: After reset the code is 01, boost 0, noise flag 0 and the gate high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 00 fast, 01 auto, 10/11 slow |
| lock_i | input | 1 | Horizontal sync lock |
| vretrace_i | input | 1 | Vertical retrace period |
| vstart_i | input | 1 | Strobe at start of vertical pulse |
| line_i | input | 1 | Line strobe at the line origin |
| sync_i | input | 1 | Separated sync pulse |
| noise_cmp_i | input | 1 | Noise comparator above threshold |
| acg_en_i | input | 1 | Anti-copy sync gating enable |
| tc_o | output | 2 | Time constant: 00 fast, 01 medium, 10 slow |
| boost_o | output | 1 | Retrace boost active |
| gate_o | output | 1 | Sync pass window |
| sync_o | output | 1 | Gated sync |
| noise_o | output | 1 | Qualified noise flag |

## Verification
The assertions take line strobes and vertical strobes to be single-cycle pulses. A vertical strobe is assumed to coincide with a line strobe, and fields are assumed longer than the noise window. The gating assertion also assumes the window does not start at the line origin. The stimulus builds lines of 60 to 70 clocks and fields of 90 to 100 lines, always emitting the vertical strobe on a line strobe. Mode, lock and enable change randomly, at field starts or on line boundaries. The comparator fires freely both inside and outside the noise window, so that the window rule and the two-field rule are both exercised.

// File: rtl/hpll_tc_pkg.sv
package hpll_tc_pkg;

    typedef enum logic [1:0] {
        TC_FAST = 2'b00,
        TC_MED  = 2'b01,
        TC_SLOW = 2'b10
    } tc_e;

    typedef enum logic [1:0] {
        MD_FAST  = 2'b00,
        MD_AUTO  = 2'b01,
        MD_SLOW  = 2'b10,
        MD_SLOW2 = 2'b11
    } mode_e;

endpackage

// File: rtl/field_line_ctr.sv
module field_line_ctr #(
    parameter int VL_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vstart_i,
    input  logic            line_i,
    output logic [VL_W-1:0] vline_o
);

    typedef struct packed {
        logic [VL_W-1:0] vline;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vstart_i) begin
            st_d.vline = '0;
        end else if (line_i && (st_q.vline != '1)) begin
            st_d.vline = st_q.vline + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.vline <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign vline_o = st_q.vline;

    // R6
    vstart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vstart_i |=> (vline_o == '0));

endmodule

// File: rtl/noise_qual.sv
module noise_qual #(
    parameter int VL_W     = 10,
    parameter int NS_START = 65,
    parameter int NS_LEN   = 15
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vstart_i,
    input  logic [VL_W-1:0] vline_i,
    input  logic            cmp_i,
    output logic            noise_o
);

    localparam logic [VL_W-1:0] NS_LO = VL_W'(NS_START);
    localparam logic [VL_W-1:0] NS_HI = VL_W'(NS_START + NS_LEN - 1);

    typedef struct packed {
        logic hit;
        logic prev;
        logic flag;
    } st_t;

    st_t  st_d, st_q;
    logic in_win;

    always_comb begin
        in_win = (vline_i >= NS_LO) && (vline_i <= NS_HI);
        st_d   = st_q;
        if (vstart_i) begin
            st_d.flag = st_q.hit && st_q.prev;
            st_d.prev = st_q.hit;
            st_d.hit  = 1'b0;
        end else if (in_win && cmp_i) begin
            st_d.hit = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign noise_o = st_q.flag;

    // R7
    noise_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(noise_o) |-> $past(vstart_i));

    // R8
    noise_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(noise_o) |-> $past(vstart_i));

endmodule

// File: rtl/tc_policy.sv
module tc_policy
    import hpll_tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [1:0] mode_i,
    input  logic       lock_i,
    input  logic       noise_i,
    input  logic       vretrace_i,
    output tc_e        tc_o,
    output logic       boost_o
);

    typedef struct packed {
        tc_e  tc;
        logic boost;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (line_i) begin
            if (mode_i == MD_FAST) begin
                st_d.tc    = TC_FAST;
                st_d.boost = 1'b0;
            end else if (!lock_i) begin
                st_d.tc    = TC_MED;
                st_d.boost = 1'b0;
            end else if ((mode_i == MD_AUTO) && !noise_i) begin
                st_d.tc    = TC_MED;
                st_d.boost = vretrace_i;
            end else begin
                st_d.tc    = TC_SLOW;
                st_d.boost = vretrace_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.tc    <= TC_MED;
            st_q.boost <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_o    = st_q.tc;
    assign boost_o = st_q.boost;

    // R1
    fast_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && (mode_i == 2'b00)) |=> ((tc_o == TC_FAST) && !boost_o));

    // R4
    unlock_med_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && !lock_i && (mode_i != 2'b00)) |=> ((tc_o == TC_MED) && !boost_o));

    // R5
    tc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_i |=> ($stable(tc_o) && $stable(boost_o)));

endmodule

// File: rtl/sync_gate.sv
module sync_gate
    import hpll_tc_pkg::*;
#(
    parameter int VL_W      = 10,
    parameter int PIX_W     = 9,
    parameter int SYNC_POS  = 32,
    parameter int HALF_WIN  = 21,
    parameter int ACG_START = 11,
    parameter int PIC_START = 23
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_i,
    input  logic [VL_W-1:0] vline_i,
    input  tc_e             tc_i,
    input  logic [1:0]      mode_i,
    input  logic            noise_i,
    input  logic            acg_en_i,
    input  logic            sync_i,
    output logic            gate_o,
    output logic            sync_o
);

    localparam logic [PIX_W-1:0] WIN_LO = PIX_W'(SYNC_POS - HALF_WIN);
    localparam logic [PIX_W-1:0] WIN_HI = PIX_W'(SYNC_POS + HALF_WIN);
    localparam logic [VL_W-1:0]  ACG_LO = VL_W'(ACG_START);
    localparam logic [VL_W-1:0]  ACG_HI = VL_W'(PIC_START - 1);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
    } st_t;

    st_t  st_d, st_q;
    logic in_win;
    logic acg_band;
    logic acg_on;
    logic narrow;

    always_comb begin
        st_d = st_q;
        if (line_i) begin
            st_d.pix = '0;
        end else if (st_q.pix != '1) begin
            st_d.pix = st_q.pix + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pix <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        in_win   = (st_q.pix >= WIN_LO) && (st_q.pix <= WIN_HI);
        acg_band = (vline_i >= ACG_LO) && (vline_i <= ACG_HI);
        acg_on   = acg_band && acg_en_i && !noise_i &&
                   ((mode_i == MD_FAST) || (mode_i == MD_AUTO));
        narrow   = (tc_i == TC_SLOW) || acg_on;
        gate_o   = narrow ? in_win : 1'b1;
        sync_o   = sync_i && gate_o;
    end

    // R9
    slow_origin_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i ##1 (tc_i == TC_SLOW)) |-> !gate_o);

endmodule

// File: rtl/hpll_tc_ctrl.sv
module hpll_tc_ctrl
    import hpll_tc_pkg::*;
#(
    parameter int VL_W      = 10,
    parameter int PIX_W     = 9,
    parameter int NS_START  = 65,
    parameter int NS_LEN    = 15,
    parameter int SYNC_POS  = 32,
    parameter int HALF_WIN  = 21,
    parameter int ACG_START = 11,
    parameter int PIC_START = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       lock_i,
    input  logic       vretrace_i,
    input  logic       vstart_i,
    input  logic       line_i,
    input  logic       sync_i,
    input  logic       noise_cmp_i,
    input  logic       acg_en_i,
    output logic [1:0] tc_o,
    output logic       boost_o,
    output logic       gate_o,
    output logic       sync_o,
    output logic       noise_o
);

    logic [VL_W-1:0] vline_w;
    logic            noise_w;
    tc_e             tc_w;

    field_line_ctr #(.VL_W(VL_W)) u_lines (
        .clk      (clk),
        .rst_n    (rst_n),
        .vstart_i (vstart_i),
        .line_i   (line_i),
        .vline_o  (vline_w)
    );

    noise_qual #(
        .VL_W     (VL_W),
        .NS_START (NS_START),
        .NS_LEN   (NS_LEN)
    ) u_noise (
        .clk      (clk),
        .rst_n    (rst_n),
        .vstart_i (vstart_i),
        .vline_i  (vline_w),
        .cmp_i    (noise_cmp_i),
        .noise_o  (noise_w)
    );

    tc_policy u_policy (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_i     (line_i),
        .mode_i     (mode_i),
        .lock_i     (lock_i),
        .noise_i    (noise_w),
        .vretrace_i (vretrace_i),
        .tc_o       (tc_w),
        .boost_o    (boost_o)
    );

    sync_gate #(
        .VL_W      (VL_W),
        .PIX_W     (PIX_W),
        .SYNC_POS  (SYNC_POS),
        .HALF_WIN  (HALF_WIN),
        .ACG_START (ACG_START),
        .PIC_START (PIC_START)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .vline_i  (vline_w),
        .tc_i     (tc_w),
        .mode_i   (mode_i),
        .noise_i  (noise_w),
        .acg_en_i (acg_en_i),
        .sync_i   (sync_i),
        .gate_o   (gate_o),
        .sync_o   (sync_o)
    );

    assign tc_o    = tc_w;
    assign noise_o = noise_w;

    // R11
    gate_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_o |-> ((tc_o == 2'b10) || (acg_en_i && !noise_o && !mode_i[1])));

    // R2
    auto_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_i && lock_i && (mode_i == 2'b01) && !noise_o) |=> (tc_o == 2'b01));

endmodule

// File: tb/tb_hpll_tc_ctrl.sv
module tb_hpll_tc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'b01;
    logic       lock_i = 1'b1;
    logic       vretrace_i = 1'b0;
    logic       vstart_i = 1'b0;
    logic       line_i = 1'b0;
    logic       sync_i = 1'b0;
    logic       noise_cmp_i = 1'b0;
    logic       acg_en_i = 1'b0;
    logic [1:0] tc_o;
    logic       boost_o, gate_o, sync_o, noise_o;

    always #4 clk = ~clk;

    hpll_tc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .lock_i(lock_i),
        .vretrace_i(vretrace_i), .vstart_i(vstart_i), .line_i(line_i),
        .sync_i(sync_i), .noise_cmp_i(noise_cmp_i), .acg_en_i(acg_en_i),
        .tc_o(tc_o), .boost_o(boost_o), .gate_o(gate_o), .sync_o(sync_o),
        .noise_o(noise_o)
    );

    int checks = 0;
    int errs = 0;
    bit done = 0;

    // model of the registered state, as it stands after the latest edge
    int m_vline = 1023, m_pix = 511;
    bit m_hit = 0, m_prev = 0, m_noise = 0, m_boost = 0;
    int m_tc = 1;
    string m_tag = "R12";
    int last_kind = 0;

    // stimulus generator state
    int d_pix = 1000, d_len = 60, d_line = 1000, d_flen = 95;
    int fld = 0, kind = 0;
    int seed_dummy;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_gate(input int tc, input int pix, input int vline,
                                    input int mode, input bit en, input bit nz);
        bit inwin = (pix >= 11) && (pix <= 53);
        bit acg = (vline >= 11) && (vline <= 22) && en && !nz && (mode <= 1);
        return ((tc == 2) || acg) ? int'(inwin) : 1;
    endfunction

    function automatic int exp_tc(input int mode, input bit lk, input bit nz);
        if (mode == 0) return 0;
        if (!lk) return 1;
        if (mode == 1 && !nz) return 1;
        return 2;
    endfunction

    task automatic new_field();
        int directed [6] = '{1, 2, 1, 1, 1, 0};
        last_kind = kind;
        if (fld < 6) begin
            kind = directed[fld];
            mode_i = 2'b01;
            lock_i = 1'b1;
            acg_en_i = 1'b1;
        end else begin
            kind = int'($urandom_range(0, 2));
            mode_i = 2'($urandom_range(0, 3));
            lock_i = ($urandom_range(0, 3) != 0);
            acg_en_i = $urandom_range(0, 1) != 0;
        end
        d_flen = int'($urandom_range(90, 100));
        fld++;
    endtask

    task automatic step();
        string gtag, ntag;
        int eg;
        bit nl, nv, nc;
        @(negedge clk);
        // compare outputs against model state
        chk(m_tag, int'(tc_o), m_tc);
        chk(m_tag, int'(boost_o), int'(m_boost));
        ntag = (last_kind == 2 && !m_noise) ? "R6" : (m_noise ? "R7" : "R8");
        if (m_tag == "R12") ntag = "R12";
        chk(ntag, int'(noise_o), int'(m_noise));
        eg = exp_gate(m_tc, m_pix, m_vline, int'(mode_i), acg_en_i, m_noise);
        if (m_tag == "R12") gtag = "R12";
        else if (m_tc == 2) gtag = "R9";
        else if (eg == 0 || (m_vline >= 11 && m_vline <= 22)) gtag = "R10";
        else gtag = "R11";
        chk(gtag, int'(gate_o), eg);
        chk("R11", int'(sync_o), int'(sync_i) & eg);

        // next inputs
        nl = 0; nv = 0;
        d_pix++;
        if (d_pix >= d_len) begin
            d_pix = 0;
            nl = 1;
            d_len = int'($urandom_range(60, 70));
            d_line++;
            if (d_line >= d_flen) begin
                d_line = 0;
                nv = 1;
                new_field();
            end else if (fld > 6 && $urandom_range(0, 39) == 0) begin
                lock_i = ~lock_i;
            end
        end
        line_i = nl;
        vstart_i = nv;
        vretrace_i = (d_line < 9);
        sync_i = $urandom_range(0, 1) != 0;
        if (m_vline >= 65 && m_vline <= 79 && !nv)
            nc = (kind == 1) && ($urandom_range(0, 1) != 0);
        else
            nc = ($urandom_range(0, 7) == 0);
        noise_cmp_i = nc;

        // model the coming edge
        if (nl) begin
            m_tc = exp_tc(int'(mode_i), lock_i, m_noise);
            m_boost = (m_tc == 0 || (!lock_i && mode_i != 0)) ? 1'b0 : vretrace_i;
            if (mode_i == 0) m_tag = "R1";
            else if (!lock_i) m_tag = "R4";
            else if (m_tc == 1) m_tag = "R2";
            else m_tag = "R3";
        end else begin
            m_tag = "R5";
        end
        if (nv) begin
            m_noise = m_hit && m_prev;
            m_prev = m_hit;
            m_hit = 0;
        end else if (m_vline >= 65 && m_vline <= 79 && nc) begin
            m_hit = 1;
        end
        if (nv) m_vline = 0;
        else if (nl && m_vline < 1023) m_vline++;
        if (nl) m_pix = 0;
        else if (m_pix < 511) m_pix++;
    endtask

    initial begin
        seed_dummy = $urandom(1234);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        while (fld <= 14 && !done) step();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errs);
            $finish;
        end
    end

endmodule